// File: doc/BRIEF.md
# Plucked-String Feedback Filter Chain

This block is a streaming audio processor for signed 8-bit samples at a 44.1 kHz sample rate. It models a plucked string as a fixed, ordered chain of filters. A new sample first goes through a one-pole lowpass that shapes the pluck direction. A feedforward comb then shapes the pluck position. The comb result is added into a recirculating loop. That loop is made of an on-chip RAM delay line, a symmetric two-zero damping filter and a second one-pole lowpass. The loop output finally passes through a lowpass whose coefficient follows a decaying peak-level estimate.

Every stage is a register stage, so the block can accept one sample per clock while earlier samples are still in later stages. All arithmetic is fixed point with Q1.7 coefficients. Each stage result is rounded and saturated back to 8 bits. All coefficients are parameters that are loaded into the stage registers at reset. Only the delay-line length is a run-time input.

Top module: `plk_string_chain`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `out_valid` and `out_data` are 0. Within 4 clocks after `rst_n` rises, `in_ready` is 1, and it then stays 1.
- R2: A sample accepted in cycle c (`in_valid` and `in_ready` both high) appears on `out_valid`/`out_data` in cycle c+4. Every accepted sample yields exactly one output, in order. `lat_cycles` always reads 4.
- R3: Pick stage: a[n] = rs((128-PICK_A)*x[n] + PICK_A*a[n-1]), with a[-1]=0.
- R4: Comb stage: b[n] = rs(128*a[n] - COMB_G*a[n-COMB_DLY]), where a at a negative index is 0.
- R5: Loop: d[n] = s[n-L] for n >= L, otherwise 0. The damping output is e[n] = rs(H0*d[n] + H1*d[n-1] + H0*d[n-2]). The loop lowpass is f[n] = rs((128-PICK_L)*e[n] + PICK_L*f[n-1]). The summing node is s[n] = sat(b[n] + f[n]).
- R6: Level stage: p[n] = max(|s[n]|*256, p[n-1] - floor(p[n-1]/256)) with p[-1]=0. The index k is 3 if p[n] >= 32768, otherwise bits 14:13 of p[n]. The coefficient K is byte k of `LVL_TAB`, where byte 0 is the least significant byte. The output is y[n] = rs((128-K)*s[n] + K*y[n-1]).
- R7: The delay length L is `dly_len` clamped to the range 2..1024 (0 or 1 becomes 2, and anything above 1024 becomes 1024). L is taken from the cycle of the first accepted sample after reset. Later changes to `dly_len` have no effect until the next reset.
- R8: Cycles without an accepted sample change no filter state. `out_data` holds its last value while `out_valid` is low.
- R9: rs(v) is floor((v+64)/128) saturated to [-128,127]. sat(v) saturates v to [-128,127]. Samples are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 8 | Signed input sample |
| dly_len | input | 11 | Requested loop delay in samples |
| out_valid | output | 1 | Output sample present |
| out_data | output | 8 | Signed output sample |
| lat_cycles | output | 4 | Fixed input-to-output latency in cycles |

## Verification
The assertions assume that `dly_len` is stable from the first accepted sample until reset, or that its changes can be ignored. They also assume that `in_valid` is driven only while the block is out of reset. The bench drives inputs only at the falling edge and only after `in_ready` has risen. It changes `dly_len` after the first sample only in the scenario that tests the freeze. It uses bubble gaps and back-to-back bursts so that both the stall path and the full-rate path are exercised.

// File: rtl/plk_pkg.sv
package plk_pkg;
  localparam int SW   = 8;
  localparam int AccW = 18;

  typedef logic signed [SW-1:0]   smp_t;
  typedef logic signed [SW:0]     cf_t;
  typedef logic signed [AccW-1:0] acc_t;

  // three-term multiply-accumulate, widened before the products
  function automatic acc_t mac3(cf_t c0, smp_t x0, cf_t c1, smp_t x1, cf_t c2, smp_t x2);
    acc_t w0, w1, w2, v0, v1, v2;
    w0 = c0; w1 = c1; w2 = c2;
    v0 = x0; v1 = x1; v2 = x2;
    return w0 * v0 + w1 * v1 + w2 * v2;
  endfunction

  // Q1.7 product back to a sample: round half up, then clamp
  function automatic smp_t rnd_sat(acc_t acc);
    acc_t t;
    t = (acc + acc_t'(64)) >>> 7;
    if (t > acc_t'(127))       return smp_t'(127);
    else if (t < acc_t'(-128)) return smp_t'(-128);
    else                       return t[SW-1:0];
  endfunction

  function automatic smp_t sat_add(smp_t p, smp_t q);
    logic signed [SW:0] s;
    s = $signed({p[SW-1], p}) + $signed({q[SW-1], q});
    if (s > 9'sd127)       return smp_t'(127);
    else if (s < -9'sd128) return smp_t'(-128);
    else                   return s[SW-1:0];
  endfunction
endpackage

// File: rtl/plk_onepole.sv
module plk_onepole
  import plk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  cf_t  coef,
  input  smp_t x,
  output smp_t y_nxt,
  output smp_t y_q
);
  smp_t y_d;

  always_comb begin
    y_nxt = rnd_sat(mac3(cf_t'(128) - coef, x, coef, y_q, '0, '0));
    y_d   = en ? y_nxt : y_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= '0;
    else        y_q <= y_d;
  end
endmodule

// File: rtl/plk_delay_ram.sv
module plk_delay_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/plk_level_coef.sv
module plk_level_coef
  import plk_pkg::*;
#(
  parameter logic [31:0] LVL_TAB = 32'h0020_4060
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  smp_t s,
  output cf_t  coef
);
  logic [15:0] pk_q, pk_d, pk_nxt, dec, m16;
  logic [7:0]  mag;
  logic [1:0]  idx;

  always_comb begin
    mag    = s[SW-1] ? 8'(-s) : 8'(s);
    m16    = {mag, 8'h00};
    dec    = pk_q - (pk_q >> 8);
    pk_nxt = (m16 > dec) ? m16 : dec;
    idx    = pk_nxt[15] ? 2'd3 : pk_nxt[14:13];
    coef   = cf_t'({1'b0, LVL_TAB[{idx, 3'b000} +: 8]});
    pk_d   = en ? pk_nxt : pk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pk_q <= '0;
    else        pk_q <= pk_d;
  end

  // peak only falls by its own decay step, never faster
  p_peak_decay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pk_q >= $past(pk_q) - ($past(pk_q) >> 8));
endmodule

// File: rtl/plk_string_chain.sv
module plk_string_chain
  import plk_pkg::*;
#(
  parameter int               DEPTH    = 1024,
  parameter int               COMB_DLY = 3,
  parameter logic signed [7:0] PICK_A  = 8'sd64,
  parameter logic signed [7:0] COMB_G  = 8'sd64,
  parameter logic signed [7:0] DAMP_H0 = 8'sd32,
  parameter logic signed [7:0] DAMP_H1 = 8'sd48,
  parameter logic signed [7:0] PICK_L  = 8'sd32,
  parameter logic [31:0]       LVL_TAB = 32'h0020_4060
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic [10:0] dly_len,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic [3:0]  lat_cycles
);
  localparam int AW  = $clog2(DEPTH);
  localparam int LW  = AW + 1;
  localparam int LAT = 4;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_n_i, rdy_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s1, rst_n_i} <= 2'b00;
    else        {rst_s1, rst_n_i} <= {1'b1, rst_s1};
  end
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rdy_q <= 1'b0;
    else          rdy_q <= 1'b1;
  end

  logic accept;
  assign accept     = in_valid & rdy_q;
  assign in_ready   = rdy_q;
  assign lat_cycles = 4'(LAT);

  // ---- length capture ----
  logic          locked_q, locked_d;
  logic [LW-1:0] len_q, len_d, len_c;
  always_comb begin
    if (dly_len < 11'(2))          len_c = LW'(2);
    else if (dly_len > 11'(DEPTH)) len_c = LW'(DEPTH);
    else                           len_c = LW'(dly_len);
    len_d    = locked_q ? len_q : len_c;
    locked_d = locked_q | accept;
  end

  // ---- stage A: pluck-direction lowpass ----
  smp_t a_q, a_nxt;
  logic vA_q;
  plk_onepole u_pick (
    .clk(clk), .rst_n(rst_n_i), .en(accept), .coef(cf_t'(PICK_A)),
    .x(smp_t'(in_data)), .y_nxt(a_nxt), .y_q(a_q)
  );

  // ---- stage B: pluck-position comb ----
  smp_t ah_q [COMB_DLY];
  for (genvar g = 0; g < COMB_DLY; g++) begin : g_comb
    smp_t ah_d;
    if (g == 0) begin : g_head
      assign ah_d = vA_q ? a_q : ah_q[0];
    end else begin : g_tail
      assign ah_d = vA_q ? ah_q[g-1] : ah_q[g];
    end
    always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i) ah_q[g] <= '0;
      else          ah_q[g] <= ah_d;
    end
  end

  smp_t          b_q, b_d;
  logic          vB_q, prm_q, prm_d;
  logic [AW-1:0] cnt_q, cnt_d, wa_q, wa_d, rd_addr;
  logic [LW-1:0] fill_q, fill_d;

  always_comb begin
    b_d     = b_q;
    cnt_d   = cnt_q;
    fill_d  = fill_q;
    wa_d    = wa_q;
    prm_d   = prm_q;
    rd_addr = cnt_q - len_q[AW-1:0];
    if (vA_q) begin
      b_d   = rnd_sat(mac3(cf_t'(128), a_q, -cf_t'(COMB_G), ah_q[COMB_DLY-1], '0, '0));
      cnt_d = cnt_q + 1'b1;
      if (fill_q < LW'(DEPTH)) fill_d = fill_q + 1'b1;
      wa_d  = cnt_q;
      prm_d = (fill_q >= len_q);
    end
  end

  // ---- loop stage: delay line, damping, loop lowpass, summing node ----
  logic [7:0] rdat;
  smp_t d0, d1_q, d2_q, d1_d, d2_d, e_nxt, f_nxt, f_q, s_q, s_d, s_nxt;
  logic vS_q;

  plk_delay_ram #(.DEPTH(DEPTH), .DW(SW)) u_dly (
    .clk(clk), .we(vB_q), .waddr(wa_q), .wdata(s_nxt),
    .re(vA_q), .raddr(rd_addr), .rdata(rdat)
  );

  always_comb begin
    d0    = prm_q ? smp_t'(rdat) : '0;
    e_nxt = rnd_sat(mac3(cf_t'(DAMP_H0), d0, cf_t'(DAMP_H1), d1_q, cf_t'(DAMP_H0), d2_q));
    s_nxt = sat_add(b_q, f_nxt);
    d1_d  = vB_q ? d0   : d1_q;
    d2_d  = vB_q ? d1_q : d2_q;
    s_d   = vB_q ? s_nxt : s_q;
  end

  plk_onepole u_loop_lp (
    .clk(clk), .rst_n(rst_n_i), .en(vB_q), .coef(cf_t'(PICK_L)),
    .x(e_nxt), .y_nxt(f_nxt), .y_q(f_q)
  );

  // ---- output stage: level-dependent lowpass ----
  cf_t  k_coef;
  smp_t o_nxt, o_q;
  logic ov_q;

  plk_level_coef #(.LVL_TAB(LVL_TAB)) u_lvl (
    .clk(clk), .rst_n(rst_n_i), .en(vS_q), .s(s_q), .coef(k_coef)
  );
  plk_onepole u_out_lp (
    .clk(clk), .rst_n(rst_n_i), .en(vS_q), .coef(k_coef),
    .x(s_q), .y_nxt(o_nxt), .y_q(o_q)
  );
  assign out_data  = o_q;
  assign out_valid = ov_q;

  // ---- registers ----
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      locked_q <= 1'b0;
      len_q    <= LW'(2);
      vA_q     <= 1'b0;
      vB_q     <= 1'b0;
      vS_q     <= 1'b0;
      ov_q     <= 1'b0;
      b_q      <= '0;
      cnt_q    <= '0;
      fill_q   <= '0;
      wa_q     <= '0;
      prm_q    <= 1'b0;
      d1_q     <= '0;
      d2_q     <= '0;
      s_q      <= '0;
    end else begin
      locked_q <= locked_d;
      len_q    <= len_d;
      vA_q     <= accept;
      vB_q     <= vA_q;
      vS_q     <= vB_q;
      ov_q     <= vS_q;
      b_q      <= b_d;
      cnt_q    <= cnt_d;
      fill_q   <= fill_d;
      wa_q     <= wa_d;
      prm_q    <= prm_d;
      d1_q     <= d1_d;
      d2_q     <= d2_d;
      s_q      <= s_d;
    end
  end

  // ---- assertions ----
  p_ready_holds_r1: assert property (@(posedge clk) disable iff (!rst_n_i)
    rdy_q |=> rdy_q);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    accept |=> ##3 out_valid);
  p_no_spurious_out_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(out_valid) |-> $past(accept, 4));
  p_len_range_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    len_q >= LW'(2) && len_q <= LW'(DEPTH));
  p_len_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    locked_q |=> $stable(len_q));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !vS_q |=> $stable(out_data));
  p_loop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !vB_q |=> $stable(f_q) && $stable(s_q));
endmodule

// File: tb/test_plk_string_chain.sv
`timescale 1ns/1ps
module test_plk_string_chain;
  localparam int PA = 64, CG = 64, H0 = 32, H1 = 48, PL = 32, M = 3;
  localparam int LVK [4] = '{96, 64, 32, 0};

  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic        in_ready, out_valid;
  logic [7:0]  in_data = '0, out_data;
  logic [10:0] dly_len = 11'd5;
  logic [3:0]  lat_cycles;

  always #2.5 clk = ~clk;

  plk_string_chain #(
    .DEPTH(1024), .COMB_DLY(M), .PICK_A(8'sd64), .COMB_G(8'sd64),
    .DAMP_H0(8'sd32), .DAMP_H1(8'sd48), .PICK_L(8'sd32), .LVL_TAB(32'h0020_4060)
  ) i_plk_string_chain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .dly_len(dly_len), .out_valid(out_valid),
    .out_data(out_data), .lat_cycles(lat_cycles)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---- reference model, written from the requirements ----
  int m_n, m_L;
  longint ma, mf, mo, md1, md2, mpk;
  longint ah [4096];
  longint sh [4096];

  function automatic longint m_rs(longint v);
    longint r;
    r = (v + 64) >>> 7;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  task automatic m_reset(input int len);
    m_n = 0; ma = 0; mf = 0; mo = 0; md1 = 0; md2 = 0; mpk = 0;
    m_L = (len < 2) ? 2 : (len > 1024) ? 1024 : len;
  endtask

  function automatic longint m_step(input longint x);
    longint a, am, b, d0, e, f, s, mag, k;
    int idx;
    a = m_rs((128 - PA) * x + PA * ma); ma = a; ah[m_n] = a;
    am = (m_n >= M) ? ah[m_n - M] : 0;
    b = m_rs(128 * a - CG * am);
    d0 = (m_n >= m_L) ? sh[m_n - m_L] : 0;
    e = m_rs(H0 * d0 + H1 * md1 + H0 * md2);
    md2 = md1; md1 = d0;
    f = m_rs((128 - PL) * e + PL * mf); mf = f;
    s = b + f;
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    sh[m_n] = s;
    mag = (s < 0) ? -s : s;
    mpk = (mag * 256 > mpk - mpk / 256) ? mag * 256 : mpk - mpk / 256;
    idx = (mpk >= 32768) ? 3 : int'((mpk / 8192) % 4);
    k = LVK[idx];
    mo = m_rs((128 - k) * s + k * mo);
    m_n++;
    return mo;
  endfunction

  // ---- scoreboard ----
  logic [7:0] exp_q [4096];
  int acc_c [4096];
  int wr = 0, rd = 0;
  string tag = "R3";
  bit hold_chk = 1'b0, have_last = 1'b0;
  logic [7:0] last_o;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (rd < wr) begin
          check(out_data == exp_q[rd], tag, int'($signed(out_data)), int'($signed(exp_q[rd])));
          check(cyc - acc_c[rd] == 4, "R2 latency", cyc - acc_c[rd], 4);
          rd++;
        end else begin
          check(1'b0, "R2 extra output", rd, wr);
        end
        last_o = out_data; have_last = 1'b1;
      end else if (hold_chk && have_last) begin
        check(out_data == last_o, "R8 hold", int'($signed(out_data)), int'($signed(last_o)));
      end
    end
  end

  task automatic start(input int len, input bit chk_reset);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; dly_len = 11'(len);
    have_last = 1'b0; hold_chk = 1'b0;
    repeat (3) @(negedge clk);
    if (chk_reset) begin
      check(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
      check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      check(out_data == 8'h00, "R1 data in reset", int'(out_data), 0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(lat_cycles == 4'd4, "R2 latency port", int'(lat_cycles), 4);
    m_reset(len); wr = 0; rd = 0;
  endtask

  task automatic send(input logic [7:0] x, input int gap);
    in_valid = 1'b1; in_data = x;
    acc_c[wr] = cyc;
    exp_q[wr] = 8'(m_step(longint'($signed(x))));
    wr++;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
    check(rd == wr, "R2 output count", rd, wr);
  endtask

  logic [31:0] lfsr = 32'h1234_5678;
  function automatic logic [7:0] rnd8();
    lfsr = lfsr * 32'd1103515245 + 32'd12345;
    return lfsr[23:16];
  endfunction

  initial begin
    // impulse through a short loop: echoes every 5 samples (R5)
    start(5, 1'b1);
    tag = "R5 loop impulse";
    send(8'd100, 0);
    for (int i = 0; i < 60; i++) send(8'd0, 0);
    drain();

    // every input code back to back (R3 R4 R9)
    start(37, 1'b0);
    tag = "R3 R4 R9 code sweep";
    for (int i = 0; i < 256; i++) send(8'(i), 0);
    for (int i = 0; i < 20; i++) send((i % 2) ? 8'h80 : 8'h7f, 0);
    drain();

    // loud burst then silence: peak index walks down (R6)
    start(11, 1'b0);
    tag = "R6 level lowpass";
    for (int i = 0; i < 40; i++) send((i % 2) ? 8'h81 : 8'h7f, 0);
    for (int i = 0; i < 200; i++) send(8'd0, 0);
    drain();

    // bubbles between samples must not disturb state (R8)
    start(7, 1'b0);
    tag = "R8 gapped stream";
    hold_chk = 1'b1;
    for (int i = 0; i < 120; i++) send(rnd8(), int'(rnd8() % 4));
    drain();
    hold_chk = 1'b0;

    // length frozen after the first sample (R7)
    start(9, 1'b0);
    tag = "R7 length freeze";
    send(8'd90, 0);
    dly_len = 11'd3;
    for (int i = 0; i < 50; i++) send(8'd0, 0);
    drain();

    // clamp low: 0 behaves as 2 (R7)
    start(0, 1'b0);
    tag = "R7 clamp low";
    send(8'd70, 0);
    for (int i = 0; i < 30; i++) send(8'd0, 0);
    drain();

    // clamp high: 2000 behaves as 1024 (R7)
    start(2000, 1'b0);
    tag = "R7 clamp high";
    send(8'd120, 0);
    for (int i = 0; i < 1090; i++) send((i == 500) ? 8'hc0 : 8'd0, 0);
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rd, wr);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule